// File: doc/BRIEF.md
# Video/CPU RAM Slot Arbiter

This block shares one RAM access slot per 2MHz clock between a video fetch engine and a CPU. A slot counter walks 128 slots per scanline, and a line counter walks 312 scanlines per frame. The display mode and an enhancement enable set, for every slot, whether the video engine, the CPU or nobody owns the RAM. While the video engine fetches, it takes either every slot of the active window or every other slot of it, depending on the mode. Outside that window the CPU normally gets only every other slot. With the enhancement on, the CPU gets all of them.

A CPU that asks for RAM in a slot it does not own sees a stall until its next slot comes round. Per-frame totals of video and CPU slots are latched at each frame boundary, so the bandwidth of each mode can be measured.

A small state machine tracks where the slot counters stand in the frame. It has three states:

- `RGN_FETCH`: inside the active window of a display line.
- `RGN_MARGIN`: on a display line, after the window.
- `RGN_IDLE`: on a non-display line.

It has five transitions:

- FETCH to MARGIN, after the last window slot.
- MARGIN to FETCH, at the end of a line when the next line also displays.
- MARGIN to IDLE, at the end of the last display line.
- MARGIN to FETCH, at the end of the frame.
- IDLE to FETCH, at the end of the frame.

Reset enters FETCH.

Top module: `vram_slot_arbiter`

## Requirements
- R1: While `rst_n` is low, `slot_idx` and `line_idx` read 0, `frame_done` is 0 and `cpu_stall` is 0 when no request is made.
- R2: `slot_idx` counts 0 to 127 and then wraps. `line_idx` advances on each wrap and returns to 0 after line 311.
- R3: `vid_grant` and `cpu_grant` are never both high in the same slot.
- R4: In modes 0 to 3, every slot 0 to 79 of a display line grants the video engine only.
- R5: In modes 4 to 7, slots 0 to 79 of a display line alternate. An even slot grants the CPU and an odd slot grants the video engine.
- R6: Modes 0, 1, 2, 4 and 5 display lines 0 to 255. Modes 3, 6 and 7 display lines 0 to 191. On all other lines, no slot counts as part of the active window.
- R7: With the enhancement off (`boost_en` = 0), a slot outside the active window grants the CPU when its index is even and grants nobody when it is odd.
- R8: With the enhancement on, every slot outside the active window grants the CPU.
- R9: `mode_sel` and `boost_en` take effect only on the clock edge that enters line 0, slot 0, and also while reset is held. A change in mid-frame does not alter the current frame.
- R10: A `cpu_req` in a slot without a CPU grant raises `cpu_stall` in that slot. The stall then stays high, whatever `cpu_req` does, until the next slot that grants the CPU, where it is low.
- R11: `frame_done` pulses for one cycle in slot 0 of line 0, for every frame after the first. In that cycle, `cpu_frame_slots` and `vid_frame_slots` hold the grant totals of the frame just ended.
- R12: The frame totals (CPU with the enhancement off, CPU with it on, and video) are:

  | Mode | CPU, enhancement off | CPU, enhancement on | Video |
  |---|---|---|---|
  | 0 to 2 | 9728 | 19456 | 20480 |
  | 3 | 12288 | 24576 | 15360 |
  | 4 and 5 | 19968 | 29696 | 10240 |
  | 6 | 19968 | 32256 | 7680 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2MHz slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Display mode, 0 to 7 |
| boost_en | input | 1 | Enhancement enable: CPU takes every slot outside the window |
| cpu_req | input | 1 | CPU wants RAM in this slot |
| vid_grant | output | 1 | Slot belongs to the video engine |
| cpu_grant | output | 1 | Slot belongs to the CPU |
| cpu_stall | output | 1 | Hold off the CPU RAM access |
| slot_idx | output | 7 | Current slot within the line |
| line_idx | output | 9 | Current line within the frame |
| frame_done | output | 1 | One-cycle pulse: totals are valid |
| cpu_frame_slots | output | 16 | CPU slots granted in the last frame |
| vid_frame_slots | output | 16 | Video slots granted in the last frame |

## Verification
The bench runs four whole frames, each in a different mode and enhancement setting:

- mode 0 with the enhancement off;
- mode 6 with it on;
- mode 4 with it off;
- mode 3 with it on.

Together these separate the dense and alternating window patterns, the 256-line and 192-line display heights, and the idle and CPU-owned slots outside the window. Each setting is applied in the middle of the frame before it, so a design that switches patterns before the frame boundary shows wrong grants for the rest of that frame. A pseudo-random CPU request stream lands both inside and outside CPU slots, which exercises stall raising, holding across dropped requests and release. The latched totals are compared against the fixed per-mode figures.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    typedef enum logic [1:0] {
        RGN_FETCH  = 2'd0,
        RGN_MARGIN = 2'd1,
        RGN_IDLE   = 2'd2
    } region_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       boost;
    } arb_cfg_t;

    // video takes every slot of the window
    function automatic logic mode_dense(input logic [2:0] m);
        return (m <= 3'd3);
    endfunction

    // character-row modes with the shorter display height
    function automatic logic mode_short(input logic [2:0] m);
        return (m == 3'd3) || (m >= 3'd6);
    endfunction

endpackage

// File: rtl/slot_timebase.sv
module slot_timebase #(
    parameter int SLOTS = 128,
    parameter int LINES = 312,
    localparam int SW = $clog2(SLOTS),
    localparam int LW = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] slot,
    output logic [LW-1:0] line,
    output logic          line_end,
    output logic          frame_end
);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
    localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

    assign line_end  = (slot == SLOT_LAST);
    assign frame_end = line_end && (line == LINE_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            line <= '0;
        end else if (line_end) begin
            slot <= '0;
            line <= frame_end ? '0 : line + 1'b1;
        end else begin
            slot <= slot + 1'b1;
        end
    end

endmodule

// File: rtl/region_fsm.sv
module region_fsm
    import slot_arb_pkg::*;
#(
    parameter int SLOTS        = 128,
    parameter int LINES        = 312,
    parameter int ACTIVE_SLOTS = 80,
    parameter int TALL_LINES   = 256,
    parameter int SHORT_LINES  = 192,
    localparam int SW = $clog2(SLOTS),
    localparam int LW = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] slot,
    input  logic [LW-1:0] line,
    input  logic          line_end,
    input  logic          frame_end,
    input  arb_cfg_t      cfg,
    output region_e       state,
    output logic          vid_grant,
    output logic          cpu_grant
);
    localparam logic [SW-1:0] ACT_LAST   = SW'(ACTIVE_SLOTS - 1);
    localparam logic [LW-1:0] TALL_LAST  = LW'(TALL_LINES - 1);
    localparam logic [LW-1:0] SHORT_LAST = LW'(SHORT_LINES - 1);

    region_e       state_n;
    logic [LW-1:0] disp_last;

    assign disp_last = mode_short(cfg.mode) ? SHORT_LAST : TALL_LAST;

    always_comb begin
        state_n = state;
        unique case (state)
            RGN_FETCH: begin
                if (slot == ACT_LAST) state_n = RGN_MARGIN;
            end
            RGN_MARGIN: begin
                if (frame_end)                          state_n = RGN_FETCH;
                else if (line_end && line == disp_last) state_n = RGN_IDLE;
                else if (line_end)                      state_n = RGN_FETCH;
            end
            RGN_IDLE: begin
                if (frame_end) state_n = RGN_FETCH;
            end
            default: state_n = RGN_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RGN_FETCH;
        else        state <= state_n;
    end

    always_comb begin
        vid_grant = 1'b0;
        cpu_grant = 1'b0;
        unique case (state)
            RGN_FETCH: begin
                if (mode_dense(cfg.mode)) begin
                    vid_grant = 1'b1;
                end else begin
                    vid_grant = slot[0];
                    cpu_grant = ~slot[0];
                end
            end
            RGN_MARGIN, RGN_IDLE: begin
                cpu_grant = cfg.boost | ~slot[0];
            end
            default: begin
                vid_grant = 1'b0;
                cpu_grant = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/stall_tracker.sv
module stall_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_grant,
    output logic cpu_stall
);
    logic pend_q;

    assign cpu_stall = !cpu_grant && (cpu_req || pend_q);

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= cpu_stall;
    end

endmodule

// File: rtl/frame_meter.sv
module frame_meter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vid_grant,
    input  logic          cpu_grant,
    input  logic          frame_end,
    output logic          frame_done,
    output logic [CW-1:0] cpu_total,
    output logic [CW-1:0] vid_total
);
    logic [CW-1:0] cpu_cnt;
    logic [CW-1:0] vid_cnt;
    logic [CW-1:0] cpu_next;
    logic [CW-1:0] vid_next;

    assign cpu_next = cpu_cnt + CW'(cpu_grant);
    assign vid_next = vid_cnt + CW'(vid_grant);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_cnt    <= '0;
            vid_cnt    <= '0;
            cpu_total  <= '0;
            vid_total  <= '0;
            frame_done <= 1'b0;
        end else if (frame_end) begin
            cpu_total  <= cpu_next;
            vid_total  <= vid_next;
            cpu_cnt    <= '0;
            vid_cnt    <= '0;
            frame_done <= 1'b1;
        end else begin
            cpu_cnt    <= cpu_next;
            vid_cnt    <= vid_next;
            frame_done <= 1'b0;
        end
    end

endmodule

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter
    import slot_arb_pkg::*;
#(
    parameter int SLOTS_PER_LINE  = 128,
    parameter int LINES_PER_FRAME = 312,
    parameter int ACTIVE_SLOTS    = 80,
    parameter int TALL_LINES      = 256,
    parameter int SHORT_LINES     = 192,
    localparam int SW = $clog2(SLOTS_PER_LINE),
    localparam int LW = $clog2(LINES_PER_FRAME),
    localparam int CW = $clog2(SLOTS_PER_LINE * LINES_PER_FRAME + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_sel,
    input  logic          boost_en,
    input  logic          cpu_req,
    output logic          vid_grant,
    output logic          cpu_grant,
    output logic          cpu_stall,
    output logic [SW-1:0] slot_idx,
    output logic [LW-1:0] line_idx,
    output logic          frame_done,
    output logic [CW-1:0] cpu_frame_slots,
    output logic [CW-1:0] vid_frame_slots
);
    logic     line_end;
    logic     frame_end;
    arb_cfg_t cfg_q;
    region_e  region;

    // configuration is frozen for a whole frame
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            cfg_q.mode  <= mode_sel;
            cfg_q.boost <= boost_en;
        end
    end

    slot_timebase #(
        .SLOTS (SLOTS_PER_LINE),
        .LINES (LINES_PER_FRAME)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot_idx),
        .line      (line_idx),
        .line_end  (line_end),
        .frame_end (frame_end)
    );

    region_fsm #(
        .SLOTS        (SLOTS_PER_LINE),
        .LINES        (LINES_PER_FRAME),
        .ACTIVE_SLOTS (ACTIVE_SLOTS),
        .TALL_LINES   (TALL_LINES),
        .SHORT_LINES  (SHORT_LINES)
    ) u_region (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot_idx),
        .line      (line_idx),
        .line_end  (line_end),
        .frame_end (frame_end),
        .cfg       (cfg_q),
        .state     (region),
        .vid_grant (vid_grant),
        .cpu_grant (cpu_grant)
    );

    stall_tracker u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_grant (cpu_grant),
        .cpu_stall (cpu_stall)
    );

    frame_meter #(
        .CW (CW)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_grant  (vid_grant),
        .cpu_grant  (cpu_grant),
        .frame_end  (frame_end),
        .frame_done (frame_done),
        .cpu_total  (cpu_frame_slots),
        .vid_total  (vid_frame_slots)
    );

endmodule

// File: rtl/vram_slot_arbiter_chk.sv
module vram_slot_arbiter_chk
    import slot_arb_pkg::*;
#(
    parameter int SLOTS       = 128,
    parameter int LINES       = 312,
    parameter int ACTIVE      = 80,
    parameter int SHORT_LINES = 192,
    localparam int SW = $clog2(SLOTS),
    localparam int LW = $clog2(LINES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] slot_idx,
    input logic [LW-1:0] line_idx,
    input logic          frame_end,
    input arb_cfg_t      cfg_q,
    input logic          cpu_req,
    input logic          vid_grant,
    input logic          cpu_grant,
    input logic          cpu_stall,
    input logic          frame_done
);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
    localparam logic [SW-1:0] ACT_SLOTS = SW'(ACTIVE);
    localparam logic [LW-1:0] MIN_DISP  = LW'(SHORT_LINES);

    // R3
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vid_grant && cpu_grant));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != SLOT_LAST) |=> (slot_idx == $past(slot_idx) + 1'b1));

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (slot_idx == '0 && line_idx == '0));

    // R4
    dense_video_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode <= 3'd3 && slot_idx < ACT_SLOTS && line_idx < MIN_DISP) |-> vid_grant);

    // R8
    boost_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.boost && slot_idx >= ACT_SLOTS) |-> cpu_grant);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(cfg_q));

    // R10
    stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_grant |-> !cpu_stall);

    // R10
    stall_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_grant) |-> cpu_stall);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |=> (cpu_grant || cpu_stall));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

bind vram_slot_arbiter vram_slot_arbiter_chk #(
    .SLOTS       (SLOTS_PER_LINE),
    .LINES       (LINES_PER_FRAME),
    .ACTIVE      (ACTIVE_SLOTS),
    .SHORT_LINES (SHORT_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_idx   (slot_idx),
    .line_idx   (line_idx),
    .frame_end  (frame_end),
    .cfg_q      (cfg_q),
    .cpu_req    (cpu_req),
    .vid_grant  (vid_grant),
    .cpu_grant  (cpu_grant),
    .cpu_stall  (cpu_stall),
    .frame_done (frame_done)
);

// File: tb/vram_slot_arbiter_bench.sv
module vram_slot_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 128;
    localparam int NLINE = 312;
    localparam int FRAME = NSLOT * NLINE;
    localparam int TOTAL = 4 * FRAME + 2;

    typedef struct {
        bit vid;
        bit cpu;
        bit stall;
        int slot;
        int line;
        int tag;
    } exp_t;

    typedef struct {
        int cpu;
        int vid;
    } tot_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  mode_sel;
    logic        boost_en;
    logic        cpu_req;
    logic        vid_grant;
    logic        cpu_grant;
    logic        cpu_stall;
    logic [6:0]  slot_idx;
    logic [8:0]  line_idx;
    logic        frame_done;
    logic [15:0] cpu_frame_slots;
    logic [15:0] vid_frame_slots;

    int   errors = 0;
    int   checks = 0;
    int   frames_seen = 0;
    bit   finished = 0;
    exp_t exp_q[$];
    tot_t tot_q[$];

    // bench model state
    int m_mode, m_slot, m_line;
    bit m_boost, m_pend, m_cpu, r9_flag;
    int unsigned rng = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vram_slot_arbiter u_vram_slot_arbiter (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode_sel        (mode_sel),
        .boost_en        (boost_en),
        .cpu_req         (cpu_req),
        .vid_grant       (vid_grant),
        .cpu_grant       (cpu_grant),
        .cpu_stall       (cpu_stall),
        .slot_idx        (slot_idx),
        .line_idx        (line_idx),
        .frame_done      (frame_done),
        .cpu_frame_slots (cpu_frame_slots),
        .vid_frame_slots (vid_frame_slots)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // R12: frame totals per mode and enhancement
    function automatic tot_t frame_totals(input int mode, input bit boost);
        tot_t t;
        if (mode <= 2)      begin t.cpu = boost ? 19456 : 9728;  t.vid = 20480; end
        else if (mode == 3) begin t.cpu = boost ? 24576 : 12288; t.vid = 15360; end
        else if (mode <= 5) begin t.cpu = boost ? 29696 : 19968; t.vid = 10240; end
        else                begin t.cpu = boost ? 32256 : 19968; t.vid = 7680;  end
        return t;
    endfunction

    task automatic push_expect();
        exp_t e;
        bit   short_m;
        bit   in_win;
        int   disp;
        short_m = (m_mode == 3) || (m_mode >= 6);
        disp    = short_m ? 192 : 256;
        in_win  = (m_line < disp) && (m_slot < 80);
        e.vid = 0;
        e.cpu = 0;
        if (in_win) begin
            if (m_mode <= 3) begin
                e.vid = 1;                  // R4
                e.tag = 4;
            end else begin
                e.vid = (m_slot % 2) == 1;  // R5
                e.cpu = (m_slot % 2) == 0;
                e.tag = 5;
            end
        end else begin
            e.cpu = m_boost || ((m_slot % 2) == 0); // R7 / R8
            e.tag = m_boost ? 8 : 7;
        end
        if (m_line >= 192 && m_line < 256 && m_slot < 80) e.tag = 6; // R6
        if (r9_flag) e.tag = 9;                                       // R9
        e.stall = !e.cpu && (cpu_req || m_pend);                      // R10
        e.slot  = m_slot;
        e.line  = m_line;
        m_cpu   = e.cpu;
        exp_q.push_back(e);
    endtask

    task automatic advance();
        m_pend = !m_cpu && (cpu_req || m_pend);
        if (m_slot == NSLOT - 1) begin
            m_slot = 0;
            if (m_line == NLINE - 1) begin
                m_line = 0;
                tot_q.push_back(frame_totals(m_mode, m_boost));
                m_mode  = int'(mode_sel);
                m_boost = boost_en;
                r9_flag = 0;
            end else begin
                m_line++;
            end
        end else begin
            m_slot++;
        end
    endtask

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(vid_grant === e.vid && cpu_grant === e.cpu,
                      $sformatf("R%0d", e.tag), "grant {vid,cpu}",
                      int'({vid_grant, cpu_grant}), int'({e.vid, e.cpu}));
                check(cpu_stall === e.stall, "R10", "stall",
                      int'(cpu_stall), int'(e.stall));
                check(int'(slot_idx) == e.slot && int'(line_idx) == e.line,
                      "R2", "line*128+slot",
                      int'(line_idx) * 128 + int'(slot_idx), e.line * 128 + e.slot);
            end
            if (frame_done === 1'b1) begin
                if (tot_q.size() == 0) begin
                    check(0, "R11", "unexpected frame_done", 1, 0);
                end else begin
                    tot_t t;
                    t = tot_q.pop_front();
                    check(int'(cpu_frame_slots) == t.cpu, "R12", "cpu frame slots",
                          int'(cpu_frame_slots), t.cpu);
                    check(int'(vid_frame_slots) == t.vid, "R12", "video frame slots",
                          int'(vid_frame_slots), t.vid);
                    frames_seen++;
                end
            end
        end
    end

    // driver
    initial begin
        rst_n    = 1'b0;
        mode_sel = 3'd0;
        boost_en = 1'b0;
        cpu_req  = 1'b0;
        repeat (3) begin
            @(negedge clk);
            // R1: reset state
            check(slot_idx == 0 && line_idx == 0, "R1", "counters in reset",
                  int'(line_idx) * 128 + int'(slot_idx), 0);
            check(frame_done == 0 && cpu_stall == 0, "R1", "done/stall in reset",
                  int'({frame_done, cpu_stall}), 0);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        m_mode  = 0;
        m_boost = 0;
        m_slot  = 0;
        m_line  = 0;
        m_pend  = 0;
        r9_flag = 0;
        for (int k = 0; k < TOTAL; k++) begin
            // R9: new settings arrive mid-frame, apply only from the next frame
            if (k == 20000)             begin mode_sel = 3'd6; boost_en = 1'b1; r9_flag = 1; end
            if (k == FRAME + 20000)     begin mode_sel = 3'd4; boost_en = 1'b0; r9_flag = 1; end
            if (k == 2 * FRAME + 20000) begin mode_sel = 3'd3; boost_en = 1'b1; r9_flag = 1; end
            rng ^= rng << 13;
            rng ^= rng >> 17;
            rng ^= rng << 5;
            cpu_req = rng[3];
            push_expect();
            @(posedge clk);
            #1;
            advance();
        end
        @(negedge clk);
        // R11: one pulse per completed frame
        check(frames_seen == 4, "R11", "frames reported", frames_seen, 4);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", frames_seen, 4);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule